// File: doc/BRIEF.md
# Banked Vector Load/Store Engine

This engine carries every word moving between the vector register file and eight independent single-ported data memory banks. One command moves a single word (scalar), a run of sixteen consecutive words (unit-stride vector), or sixteen words at arbitrary offsets from a base (indexed gather and scatter, used for sparse operands). Every element is a 32-bit value. The low three bits of a word address select the bank. The remaining upper bits select the row inside that bank.

Each element gets its own address and a pending flag. In every issue cycle, each bank serves the lowest-numbered pending element that maps to it. No bank therefore sees two requests in one cycle. An indexed access then finishes in as many cycles as the most heavily loaded bank needs.

Read data returns from a bank one cycle after its request. The engine keeps the element number of every outstanding read so the word lands in the right register slot. Store data is taken from the register file in the same cycle the command is accepted.

The controller has three states:
- IDLE waits for a command. It moves to ISSUE when `cmd_valid` is high.
- ISSUE sends bank requests. It stays in ISSUE while elements remain pending after the current cycle. It moves to FINISH once the last one is sent.
- FINISH raises `done` for one cycle, then returns unconditionally to IDLE.

Top module: `vmu_top`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0 and no bank request is raised.
- R2: A word address A is sent to bank A mod 8, at row A div 8 of that bank.
- R3: Scalar load (op code 0) writes the word at `cmd_base` into element 0 of register `cmd_reg`, using one issue cycle.
- R4: Scalar store (op code 1) writes element 0 of register `cmd_reg` to word `cmd_base`, using one issue cycle.
- R5: Vector load (op code 2) fills element i of the register from word base+i, for i = 0..15. With a base that is a multiple of 8 it uses two issue cycles.
- R6: Vector store (op code 3) writes element i of the register to word base+i. With a base that is a multiple of 8 it uses two issue cycles.
- R7: Indexed load (op code 4) fills element i from word base+index[i]. Field i of `cmd_index` is bits [10*i+9 : 10*i]. The number of issue cycles equals the largest number of elements that map to any one bank.
- R8: Indexed store (op code 5) writes element i to word base+index[i]. It uses the same cycle count as R7.
- R9: If several elements of an indexed store share one address, the value from the highest-numbered of them is what remains in memory.
- R10: `done` is high for exactly one cycle. The number of rising edges from the accepting edge to the edge after which `done` is high equals the issue-cycle count. `cmd_ready` is 0 from acceptance until `done` has fallen, and a command presented while `cmd_ready` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine is idle and takes a command this cycle |
| cmd_op | input | 3 | Operation code (see R3 to R8) |
| cmd_base | input | 10 | Base word address |
| cmd_index | input | 160 | Sixteen 10-bit element offsets for indexed operations |
| cmd_reg | input | 3 | Vector register number |
| rf_rd_reg | output | 3 | Register whose contents are read for store data |
| rf_rd_data | input | 512 | All sixteen elements of that register, element i at bits [32i+31:32i] |
| rf_wr_reg | output | 3 | Register written by load responses |
| rf_wr_en | output | 8 | Per-lane write strobe, one lane per bank |
| rf_wr_elem | output | 32 | Per-lane element number, 4 bits per lane |
| rf_wr_data | output | 256 | Per-lane write data, 32 bits per lane |
| bank_req | output | 8 | Per-bank access request |
| bank_we | output | 8 | Per-bank write enable |
| bank_row | output | 56 | Per-bank row, 7 bits per bank |
| bank_wdata | output | 256 | Per-bank write data |
| bank_rdata | input | 256 | Per-bank read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The gathers go after the scheduler's cycle count with three bank-load profiles: evenly spread, one bank holding six elements, and all sixteen in one bank. A scheduler that serialised conflicts too eagerly, or sent two elements to one bank, would finish on the wrong edge or return corrupted words. A scatter with two elements aimed at one address checks the order of the writes: a scheduler that served higher-numbered elements first would leave the older value behind. A scalar store presented during a busy gather must leave its target word untouched; an engine that sampled commands outside IDLE would overwrite it. Load responses pass through a scoreboard keyed by register and element, which catches a misrouted element tag that a plain data check could miss.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

    typedef enum logic [2:0] {
        OP_SLD = 3'd0,
        OP_SST = 3'd1,
        OP_VLD = 3'd2,
        OP_VST = 3'd3,
        OP_XLD = 3'd4,
        OP_XST = 3'd5
    } vmu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } vmu_state_e;

    function automatic logic op_writes_mem(input logic [2:0] op);
        return (op == OP_SST) || (op == OP_VST) || (op == OP_XST);
    endfunction

endpackage

// File: rtl/vmu_addr_gen.sv
module vmu_addr_gen
    import vmu_pkg::*;
#(
    parameter int VLEN = 16,
    parameter int AW   = 10
) (
    input  logic [2:0]         op,
    input  logic [AW-1:0]      base,
    input  logic [VLEN*AW-1:0] index,
    output logic [VLEN*AW-1:0] elem_addr,
    output logic [VLEN-1:0]    elem_pend
);

    for (genvar i = 0; i < VLEN; i++) begin : g_elem
        localparam bit IS_FIRST = (i == 0);
        logic [AW-1:0] offs;
        logic [AW-1:0] a;
        logic          p;

        assign offs = index[i*AW +: AW];

        always_comb begin
            case (op)
                OP_SLD, OP_SST: begin
                    a = base;
                    p = IS_FIRST;
                end
                OP_VLD, OP_VST: begin
                    a = base + AW'(i);
                    p = 1'b1;
                end
                OP_XLD, OP_XST: begin
                    a = base + offs;
                    p = 1'b1;
                end
                default: begin
                    a = base;
                    p = 1'b0;
                end
            endcase
        end

        assign elem_addr[i*AW +: AW] = a;
        assign elem_pend[i]          = p;
    end

endmodule

// File: rtl/vmu_bank_sched.sv
module vmu_bank_sched #(
    parameter int NB   = 8,
    parameter int VLEN = 16,
    localparam int BW  = $clog2(NB),
    localparam int EW  = $clog2(VLEN)
) (
    input  logic [VLEN-1:0]    pend,
    input  logic [VLEN*BW-1:0] elem_bank,
    output logic [NB-1:0]      gnt_v,
    output logic [NB*EW-1:0]   gnt_idx,
    output logic [VLEN-1:0]    issued
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic          v_b;
        logic [EW-1:0] i_b;

        // Scan from the top down so the lowest matching element is kept.
        always_comb begin
            v_b = 1'b0;
            i_b = '0;
            for (int e = VLEN - 1; e >= 0; e--) begin
                if (pend[e] && (elem_bank[e*BW +: BW] == BW'(b))) begin
                    v_b = 1'b1;
                    i_b = EW'(e);
                end
            end
        end

        assign gnt_v[b]              = v_b;
        assign gnt_idx[b*EW +: EW]   = i_b;
    end

    always_comb begin
        issued = '0;
        for (int b = 0; b < NB; b++) begin
            if (gnt_v[b]) begin
                issued[gnt_idx[b*EW +: EW]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vmu_resp_tag.sv
module vmu_resp_tag #(
    parameter int NB = 8,
    parameter int EW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    rd_issue,
    input  logic [NB*EW-1:0] rd_elem,
    output logic [NB-1:0]    resp_v,
    output logic [NB*EW-1:0] resp_elem
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_v    <= '0;
            resp_elem <= '0;
        end else begin
            resp_v    <= rd_issue;
            resp_elem <= rd_elem;
        end
    end

endmodule

// File: rtl/vmu_top.sv
module vmu_top
    import vmu_pkg::*;
#(
    parameter int NB    = 8,
    parameter int VLEN  = 16,
    parameter int DW    = 32,
    parameter int AW    = 10,
    parameter int NREG  = 8,
    localparam int BW   = $clog2(NB),
    localparam int EW   = $clog2(VLEN),
    localparam int RW   = $clog2(NREG),
    localparam int ROWW = AW - BW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [AW-1:0]      cmd_base,
    input  logic [VLEN*AW-1:0] cmd_index,
    input  logic [RW-1:0]      cmd_reg,
    output logic [RW-1:0]      rf_rd_reg,
    input  logic [VLEN*DW-1:0] rf_rd_data,
    output logic [RW-1:0]      rf_wr_reg,
    output logic [NB-1:0]      rf_wr_en,
    output logic [NB*EW-1:0]   rf_wr_elem,
    output logic [NB*DW-1:0]   rf_wr_data,
    output logic [NB-1:0]      bank_req,
    output logic [NB-1:0]      bank_we,
    output logic [NB*ROWW-1:0] bank_row,
    output logic [NB*DW-1:0]   bank_wdata,
    input  logic [NB*DW-1:0]   bank_rdata,
    output logic               done
);

    vmu_state_e          state_q, state_d;
    logic [2:0]          op_q;
    logic [RW-1:0]       reg_q;
    logic [VLEN-1:0]     pend_q;
    logic [VLEN*AW-1:0]  addr_q;
    logic [DW-1:0]       wdata_q [VLEN];

    logic [VLEN*AW-1:0]  gen_addr;
    logic [VLEN-1:0]     gen_pend;
    logic [VLEN*BW-1:0]  elem_bank;
    logic [NB-1:0]       gnt_v;
    logic [NB*EW-1:0]    gnt_idx;
    logic [VLEN-1:0]     issued;
    logic [VLEN-1:0]     pend_left;
    logic                accept;
    logic                wr_op;

    vmu_addr_gen #(.VLEN(VLEN), .AW(AW)) u_addr (
        .op        (cmd_op),
        .base      (cmd_base),
        .index     (cmd_index),
        .elem_addr (gen_addr),
        .elem_pend (gen_pend)
    );

    for (genvar e = 0; e < VLEN; e++) begin : g_ebank
        assign elem_bank[e*BW +: BW] = addr_q[e*AW +: BW];
    end

    vmu_bank_sched #(.NB(NB), .VLEN(VLEN)) u_sched (
        .pend      (pend_q),
        .elem_bank (elem_bank),
        .gnt_v     (gnt_v),
        .gnt_idx   (gnt_idx),
        .issued    (issued)
    );

    assign accept    = (state_q == ST_IDLE) && cmd_valid;
    assign pend_left = pend_q & ~issued;
    assign wr_op     = op_writes_mem(op_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_ISSUE;
            ST_ISSUE:  if (pend_left == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Command context and pending set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            reg_q  <= '0;
            pend_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            op_q   <= cmd_op;
            reg_q  <= cmd_reg;
            pend_q <= gen_pend;
            addr_q <= gen_addr;
        end else if (state_q == ST_ISSUE) begin
            pend_q <= pend_left;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int e = 0; e < VLEN; e++) begin
                wdata_q[e] <= rf_rd_data[e*DW +: DW];
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        done      = 1'b0;
        bank_req  = '0;
        bank_we   = '0;
        unique case (state_q)
            ST_IDLE:   cmd_ready = 1'b1;
            ST_ISSUE: begin
                bank_req = gnt_v;
                bank_we  = wr_op ? gnt_v : '0;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    for (genvar b = 0; b < NB; b++) begin : g_port
        logic [EW-1:0] sel;
        assign sel = gnt_idx[b*EW +: EW];
        assign bank_row[b*ROWW +: ROWW] = addr_q[int'(sel)*AW + BW +: ROWW];
        assign bank_wdata[b*DW +: DW]   = wdata_q[sel];
    end

    vmu_resp_tag #(.NB(NB), .EW(EW)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue  (bank_req & ~bank_we),
        .rd_elem   (gnt_idx),
        .resp_v    (rf_wr_en),
        .resp_elem (rf_wr_elem)
    );

    assign rf_wr_data = bank_rdata;
    assign rf_wr_reg  = reg_q;
    assign rf_rd_reg  = cmd_reg;

endmodule

// File: rtl/vmu_top_chk.sv
module vmu_top_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          done,
    input logic [NB-1:0] bank_req,
    input logic [NB-1:0] bank_we,
    input logic [NB-1:0] rf_wr_en
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

    // R10
    busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (bank_req == '0));

    for (genvar b = 0; b < NB; b++) begin : g_lane
        // R7
        rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rf_wr_en[b] |-> $past(bank_req[b] && !bank_we[b]));

        // R8
        we_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_we[b] |-> bank_req[b]);
    end

endmodule

bind vmu_top vmu_top_chk #(.NB(NB)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .done      (done),
    .bank_req  (bank_req),
    .bank_we   (bank_we),
    .rf_wr_en  (rf_wr_en)
);

// File: tb/vmu_top_tb_top.sv
`timescale 1ns/1ps
module vmu_top_tb_top;

    localparam int NB = 8, VLEN = 16, DW = 32, AW = 10, NREG = 8;
    localparam int BW = 3, EW = 4, RW = 3, ROWW = AW - BW;
    localparam int ROWS = 1 << ROWW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [2:0]         cmd_op = '0;
    logic [AW-1:0]      cmd_base = '0;
    logic [VLEN*AW-1:0] cmd_index = '0;
    logic [RW-1:0]      cmd_reg = '0;
    logic [RW-1:0]      rf_rd_reg;
    logic [VLEN*DW-1:0] rf_rd_data;
    logic [RW-1:0]      rf_wr_reg;
    logic [NB-1:0]      rf_wr_en;
    logic [NB*EW-1:0]   rf_wr_elem;
    logic [NB*DW-1:0]   rf_wr_data;
    logic [NB-1:0]      bank_req;
    logic [NB-1:0]      bank_we;
    logic [NB*ROWW-1:0] bank_row;
    logic [NB*DW-1:0]   bank_wdata;
    logic [NB*DW-1:0]   bank_rdata;
    logic               done;

    vmu_top dut_i (.*);

    // Memory banks and register file models
    logic [DW-1:0] mem [NB][ROWS];
    logic [DW-1:0] rdq [NB];
    logic [DW-1:0] rf  [NREG][VLEN];

    always @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (bank_req[b]) begin
                if (bank_we[b]) mem[b][bank_row[b*ROWW +: ROWW]] <= bank_wdata[b*DW +: DW];
                else            rdq[b] <= mem[b][bank_row[b*ROWW +: ROWW]];
            end
            if (rf_wr_en[b]) rf[rf_wr_reg][rf_wr_elem[b*EW +: EW]] <= rf_wr_data[b*DW +: DW];
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = rdq[b];
        for (int e = 0; e < VLEN; e++) rf_rd_data[e*DW +: DW] = rf[rf_rd_reg][e];
    end

    function automatic logic [DW-1:0] memword(input int a);
        return mem[a % NB][(a / NB) % ROWS];
    endfunction

    // Scoreboard
    typedef struct { int rno; int elem; logic [DW-1:0] data; } item_t;
    item_t exp_q [$];
    string cur_tag = "R1";
    int errors = 0, checks = 0;
    logic [AW-1:0] ix [VLEN];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop matching register writes as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < NB; b++) begin
                if (rf_wr_en[b]) begin
                    int hit;
                    hit = -1;
                    for (int k = 0; k < exp_q.size(); k++)
                        if (hit < 0 && exp_q[k].rno == int'(rf_wr_reg) &&
                            exp_q[k].elem == int'(rf_wr_elem[b*EW +: EW])) hit = k;
                    if (hit < 0) begin
                        check(0, cur_tag, "unexpected register write elem",
                              DW'(rf_wr_elem[b*EW +: EW]), '1);
                    end else begin
                        check(rf_wr_data[b*DW +: DW] == exp_q[hit].data, cur_tag,
                              "load data", rf_wr_data[b*DW +: DW], exp_q[hit].data);
                        exp_q.delete(hit);
                    end
                end
            end
        end
    end

    // Driver
    task automatic run_cmd(input int op, input int base, input int rno,
                           input string tag, input bit poke);
        int lat, n, a;
        int cnt [NB];
        int exp_mem [int];
        bit is_ld;
        cur_tag = tag;
        is_ld = (op == 0) || (op == 2) || (op == 4);
        foreach (cnt[b]) cnt[b] = 0;
        for (int i = 0; i < VLEN; i++) begin
            if (op <= 1 && i > 0) break;
            if (op <= 1)      a = base;
            else if (op <= 3) a = (base + i) % (1 << AW);
            else              a = (base + int'(ix[i])) % (1 << AW);
            cnt[a % NB]++;
            if (is_ld) exp_q.push_back('{rno, i, memword(a)});
            else       exp_mem[a] = rf[rno][i];
        end
        lat = 0;
        foreach (cnt[b]) if (cnt[b] > lat) lat = cnt[b];
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 3'(op);
        cmd_base = AW'(base);
        cmd_reg = RW'(rno);
        for (int i = 0; i < VLEN; i++) cmd_index[i*AW +: AW] = ix[i];
        @(posedge clk);
        @(negedge clk);
        cmd_valid = poke;
        if (poke) begin
            cmd_op = 3'd1;
            cmd_base = AW'(500);
            cmd_reg = 3'd0;
            check(!cmd_ready, "R10", "ready while busy", DW'(cmd_ready), 0);
        end
        if (op <= 1) begin
            check(bank_req == NB'(1 << (base % NB)), "R2", "bank select",
                  DW'(bank_req), DW'(1 << (base % NB)));
            check(bank_row[(base % NB)*ROWW +: ROWW] == ROWW'(base / NB), "R2", "row",
                  DW'(bank_row[(base % NB)*ROWW +: ROWW]), DW'(base / NB));
        end
        n = 0;
        while (n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            cmd_valid = 1'b0;
            if (done) break;
        end
        check(n == lat, tag, "issue cycles", DW'(n), DW'(lat));
        @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, tag, "missing load writes", DW'(exp_q.size()), 0);
        exp_q.delete();
        check(cmd_ready && !done, "R10", "idle after done", DW'({cmd_ready, done}), 32'h2);
        foreach (exp_mem[k])
            check(memword(k) == exp_mem[k], tag, "stored word", memword(k), exp_mem[k]);
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < ROWS; r++) mem[b][r] = 32'hC0DE_0000 + DW'((r*NB + b) * 7);
        for (int r = 0; r < NREG; r++)
            for (int e = 0; e < VLEN; e++) rf[r][e] = 32'h5000_0000 + DW'(r*256 + e*3);
        for (int i = 0; i < VLEN; i++) ix[i] = '0;
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                check(cmd_ready == 1'b1, "R1", "cmd_ready", DW'(cmd_ready), 1);
                check(done == 1'b0, "R1", "done", DW'(done), 0);
                check(bank_req == '0, "R1", "bank_req", DW'(bank_req), 0);
                // R3 scalar load
                run_cmd(0, 13, 1, "R3", 0);
                // R4 scalar store
                rf[2][0] = 32'hDEAD_BEEF;
                run_cmd(1, 77, 2, "R4", 0);
                // R5 aligned vector load
                run_cmd(2, 40, 3, "R5", 0);
                // R6 aligned vector store
                run_cmd(3, 200, 4, "R6", 0);
                // R7 gather, evenly spread, with a command poked while busy (R10)
                for (int i = 0; i < VLEN; i++) ix[i] = AW'(i * 3);
                begin
                    logic [DW-1:0] keep;
                    keep = memword(500);
                    run_cmd(4, 16, 5, "R7", 1);
                    check(memword(500) == keep, "R10", "busy command ignored", memword(500), keep);
                end
                // R7 gather, one heavy bank
                for (int i = 0; i < VLEN; i++) ix[i] = (i < 5) ? AW'(i*8 + 3) : AW'(i);
                run_cmd(4, 64, 6, "R7", 0);
                // R7 gather, single bank
                for (int i = 0; i < VLEN; i++) ix[i] = AW'(i * 8);
                run_cmd(4, 8, 7, "R7", 0);
                // R8 scatter
                for (int i = 0; i < VLEN; i++) ix[i] = AW'(i * 5);
                run_cmd(5, 600, 3, "R8", 0);
                // R9 duplicate address scatter
                for (int i = 0; i < VLEN; i++) ix[i] = AW'(i + 40);
                ix[9] = AW'(44);
                run_cmd(5, 300, 6, "R9", 0);
                check(memword(344) == rf[6][9], "R9", "higher element kept", memword(344), rf[6][9]);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL R10 watchdog: actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule